// File: doc/BRIEF.md
# Paired-Page Translation Entry Manager

This block holds a small array of translation entries. Each entry maps one even/odd pair of virtual pages. The block carries out the four management operations that system software issues through its control registers. The caller presents the page-size register, the virtual-tag register, the two physical-half registers, the slot-select register and the replacement-slot register, together with a one-cycle operation strobe and an operation code.

A write packs those register images into an entry and stores it. The slot comes either from the slot-select register or from the replacement-slot register. A read unpacks a stored entry back into register images. A probe searches every entry for a tag match and reports the matching slot, or a miss code.

At write time the block also works out how many address bits each entry's page offset covers, from 10 to 28. A read returns this value with the entry. A small-page enable input selects between 1 KB granularity and 4 KB granularity. When 1 KB pages are off, the two lowest mask bits are forced to one and the two lowest tag bits are cleared.

Top module: `tlb_mgmt_unit`

## Requirements
- R1: After reset, all result outputs are zero, no result flag is raised, and every slot reads back as all zeros with a shift of 0.
- R2: op_kind 0 writes the slot given by the low log2(ENTRIES) bits of index_in; bit 31 of index_in has no effect. A read (op_kind 2) of that slot returns entryhi_out = {tag, 3'b000, asid}, with the tag in bits 31:11 and the asid in bits 7:0.
- R3: op_kind 1 writes the slot given by the low log2(ENTRIES) bits of random_in, ignoring index_in.
- R4: The stored mask is pagemask_in[31:11] and reads back in bits 31:11 of pagemask_out. When small_page_en is 0, the two low mask bits are stored as 1 and the two low tag bits as 0.
- R5: The physical-half registers use this layout: frame number in bits 31:6, cache attribute in bits 5:3, dirty in bit 2, valid in bit 1, global in bit 0. The stored global bit is the AND of bit 0 of both halves, and a read returns it in bit 0 of both outputs.
- R6: A mask made of 2k contiguous ones from bit 0 (k = 0..9) gives shift_out = 10 + 2k when the entry is read.
- R7: A write whose final mask is any other pattern pulses mask_err for one cycle and leaves the slot unchanged.
- R8: A probe (op_kind 3) that hits loads index_out with the matching slot number. When several slots match, the lowest-numbered slot wins.
- R9: A probe that misses loads index_out with 32'h8000_0000. index_out holds its value between probes.
- R10: A probe compares tag bits only where the entry's mask is zero. The probe tag has its two low bits cleared when small_page_en is 0. The asid comparison is skipped for entries whose global bit is set, and slots never written never match.
- R11: Every result is registered. rd_valid, probe_valid and mask_err are high for exactly the one cycle after the strobe edge, and read and probe data are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe, one cycle |
| op_kind | input | 2 | 0 indexed write, 1 replacement write, 2 read, 3 probe |
| small_page_en | input | 1 | 1 enables 1 KB page granularity |
| pagemask_in | input | 32 | Page-size register image |
| entryhi_in | input | 32 | Virtual tag and asid register image |
| entrylo0_in | input | 32 | Even-page physical half image |
| entrylo1_in | input | 32 | Odd-page physical half image |
| index_in | input | 32 | Slot-select register image |
| random_in | input | 32 | Replacement-slot register image |
| rd_valid | output | 1 | Read results valid |
| pagemask_out | output | 32 | Page-size image from a read |
| entryhi_out | output | 32 | Tag image from a read |
| entrylo0_out | output | 32 | Even-page image from a read |
| entrylo1_out | output | 32 | Odd-page image from a read |
| shift_out | output | 5 | Page-offset width of the entry read |
| probe_valid | output | 1 | Probe result valid |
| index_out | output | 32 | Probe result: slot number or miss code |
| mask_err | output | 1 | Write rejected for an illegal mask |

## Verification
Every result of this block appears in the first cycle after the clock edge that captures op_valid. Read images and shift, probe slot or miss code, and the error pulse all have a single register stage between strobe and port. The bench applies each operation at a falling edge and compares the outputs at the next falling edge, exactly one cycle later. A directed check confirms that the result flags have dropped again one cycle after that. Because a rejected write shows no visible change in its own cycle, its effect is checked by re-reading the slot afterwards.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   localparam int REG_W      = 32;
   localparam int PAGE_LSB   = 11;
   localparam int FIELD_W    = REG_W - PAGE_LSB;
   localparam int ASID_W     = 8;
   localparam int LO_LSB     = 6;
   localparam int PFN_W      = REG_W - LO_LSB;
   localparam int CA_W       = 3;
   localparam int SHIFT_W    = 5;
   localparam int BASE_SHIFT = 10;
   localparam int MAX_GROUPS = 9;
   localparam int SMALL_BITS = 2;
   localparam int GAP_W      = PAGE_LSB - ASID_W;

   typedef enum logic [1:0] {
      OP_WR_IDX = 2'd0,
      OP_WR_RND = 2'd1,
      OP_READ   = 2'd2,
      OP_PROBE  = 2'd3
   } op_e;

   typedef struct packed {
      logic               live;
      logic [FIELD_W-1:0] mask;
      logic [FIELD_W-1:0] vpn;
      logic [ASID_W-1:0]  asid;
      logic [PFN_W-1:0]   pfn0;
      logic [PFN_W-1:0]   pfn1;
      logic [CA_W-1:0]    ca0;
      logic [CA_W-1:0]    ca1;
      logic               dirty0;
      logic               dirty1;
      logic               valid0;
      logic               valid1;
      logic               glob;
      logic [SHIFT_W-1:0] shift;
   } tlb_ent_t;
endpackage

// File: rtl/tlbm_page_decode.sv
module tlbm_page_decode
   import tlbm_pkg::*;
(
   input  logic [FIELD_W-1:0] mask,
   output logic               legal,
   output logic [SHIFT_W-1:0] shift
);
   localparam int RUN_MAX = 2 * MAX_GROUPS;

   initial begin
      if (RUN_MAX > FIELD_W) $error("mask field too narrow for largest page");
   end

   always_comb begin
      legal = 1'b0;
      shift = '0;
      for (int k = 0; k <= MAX_GROUPS; k++) begin
         if (mask == FIELD_W'((64'd1 << (2 * k)) - 64'd1)) begin
            legal = 1'b1;
            shift = SHIFT_W'(BASE_SHIFT + 2 * k);
         end
      end
   end
endmodule

// File: rtl/tlbm_entry_store.sv
module tlbm_entry_store
   import tlbm_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_slot,
   input  tlb_ent_t         wr_ent,
   output tlb_ent_t         ent_q [ENTRIES]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_slot == IDX_W'(i)) ent_q[i] <= wr_ent;
         end
      end
   end
endmodule

// File: rtl/tlbm_probe_match.sv
module tlbm_probe_match
   import tlbm_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  tlb_ent_t           ent [ENTRIES],
   input  logic [FIELD_W-1:0] vpn,
   input  logic [ASID_W-1:0]  asid,
   output logic               hit,
   output logic [IDX_W-1:0]   slot
);
   logic [ENTRIES-1:0] hit_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic tag_eq;
      logic asid_ok;
      assign tag_eq  = (((ent[g].vpn ^ vpn) & ~ent[g].mask) == '0);
      assign asid_ok = ent[g].glob || (ent[g].asid == asid);
      assign hit_vec[g] = ent[g].live && tag_eq && asid_ok;
   end

   always_comb begin
      slot = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) slot = IDX_W'(i);
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/tlb_mgmt_unit.sv
module tlb_mgmt_unit
   import tlbm_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        op_valid,
   input  logic [1:0]  op_kind,
   input  logic        small_page_en,
   input  logic [31:0] pagemask_in,
   input  logic [31:0] entryhi_in,
   input  logic [31:0] entrylo0_in,
   input  logic [31:0] entrylo1_in,
   input  logic [31:0] index_in,
   input  logic [31:0] random_in,
   output logic        rd_valid,
   output logic [31:0] pagemask_out,
   output logic [31:0] entryhi_out,
   output logic [31:0] entrylo0_out,
   output logic [31:0] entrylo1_out,
   output logic [4:0]  shift_out,
   output logic        probe_valid,
   output logic [31:0] index_out,
   output logic        mask_err
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [REG_W-1:0] MISS_CODE = REG_W'(1) << (REG_W - 1);
   localparam logic [FIELD_W-1:0] LOW_BITS = FIELD_W'((1 << SMALL_BITS) - 1);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES || IDX_W >= REG_W - 1) begin : g_bad_entries
      initial $error("ENTRIES must be a power of two of at least 2");
   end

   op_e kind;
   assign kind = op_e'(op_kind);

   logic [FIELD_W-1:0] mask_raw, vpn_raw, mask_fix, vpn_fix;
   assign mask_raw = pagemask_in[REG_W-1:PAGE_LSB];
   assign vpn_raw  = entryhi_in[REG_W-1:PAGE_LSB];

   if (SMALL_BITS > 0) begin : g_small
      assign mask_fix = small_page_en ? mask_raw : (mask_raw | LOW_BITS);
      assign vpn_fix  = small_page_en ? vpn_raw  : (vpn_raw & ~LOW_BITS);
   end else begin : g_no_small
      assign mask_fix = mask_raw;
      assign vpn_fix  = vpn_raw;
   end

   logic               mask_legal;
   logic [SHIFT_W-1:0] mask_shift;

   tlbm_page_decode u_decode (
      .mask  (mask_fix),
      .legal (mask_legal),
      .shift (mask_shift)
   );

   tlb_ent_t new_ent;
   always_comb begin
      new_ent        = '0;
      new_ent.live   = 1'b1;
      new_ent.mask   = mask_fix;
      new_ent.vpn    = vpn_fix;
      new_ent.asid   = entryhi_in[ASID_W-1:0];
      new_ent.pfn0   = entrylo0_in[REG_W-1:LO_LSB];
      new_ent.pfn1   = entrylo1_in[REG_W-1:LO_LSB];
      new_ent.ca0    = entrylo0_in[LO_LSB-1:LO_LSB-CA_W];
      new_ent.ca1    = entrylo1_in[LO_LSB-1:LO_LSB-CA_W];
      new_ent.dirty0 = entrylo0_in[2];
      new_ent.dirty1 = entrylo1_in[2];
      new_ent.valid0 = entrylo0_in[1];
      new_ent.valid1 = entrylo1_in[1];
      new_ent.glob   = entrylo0_in[0] & entrylo1_in[0];
      new_ent.shift  = mask_shift;
   end

   logic             is_write, wr_en;
   logic [IDX_W-1:0] wr_slot, rd_slot;
   assign is_write = op_valid && (kind == OP_WR_IDX || kind == OP_WR_RND);
   assign wr_en    = is_write && mask_legal;
   assign wr_slot  = (kind == OP_WR_RND) ? random_in[IDX_W-1:0] : index_in[IDX_W-1:0];
   assign rd_slot  = index_in[IDX_W-1:0];

   tlb_ent_t ent_q [ENTRIES];

   tlbm_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_slot (wr_slot),
      .wr_ent  (new_ent),
      .ent_q   (ent_q)
   );

   logic             prb_hit;
   logic [IDX_W-1:0] prb_slot;

   tlbm_probe_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
      .ent  (ent_q),
      .vpn  (vpn_fix),
      .asid (entryhi_in[ASID_W-1:0]),
      .hit  (prb_hit),
      .slot (prb_slot)
   );

   tlb_ent_t sel;
   assign sel = ent_q[rd_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid     <= 1'b0;
         probe_valid  <= 1'b0;
         mask_err     <= 1'b0;
         pagemask_out <= '0;
         entryhi_out  <= '0;
         entrylo0_out <= '0;
         entrylo1_out <= '0;
         shift_out    <= '0;
         index_out    <= '0;
      end else begin
         rd_valid    <= op_valid && (kind == OP_READ);
         probe_valid <= op_valid && (kind == OP_PROBE);
         mask_err    <= is_write && !mask_legal;
         if (op_valid && kind == OP_READ) begin
            pagemask_out <= {sel.mask, {PAGE_LSB{1'b0}}};
            entryhi_out  <= {sel.vpn, {GAP_W{1'b0}}, sel.asid};
            entrylo0_out <= {sel.pfn0, sel.ca0, sel.dirty0, sel.valid0, sel.glob};
            entrylo1_out <= {sel.pfn1, sel.ca1, sel.dirty1, sel.valid1, sel.glob};
            shift_out    <= sel.shift;
         end
         if (op_valid && kind == OP_PROBE) begin
            index_out <= prb_hit ? REG_W'(prb_slot) : MISS_CODE;
         end
      end
   end
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
   parameter int ENTRIES = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        op_valid,
   input logic [1:0]  op_kind,
   input logic        rd_valid,
   input logic        probe_valid,
   input logic        mask_err,
   input logic [31:0] index_out
);
   p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'd2) |=> rd_valid);

   p_prb_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'd3) |=> probe_valid);

   p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, probe_valid, mask_err}));

   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_err |-> $past(op_valid && op_kind[1] == 1'b0));

   p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_kind == 2'd3) |=> $stable(index_out));

   p_probe_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> (index_out == 32'h8000_0000 || index_out < 32'(ENTRIES)));
endmodule

bind tlb_mgmt_unit tlbm_checker #(.ENTRIES(ENTRIES)) u_tlbm_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .op_kind     (op_kind),
   .rd_valid    (rd_valid),
   .probe_valid (probe_valid),
   .mask_err    (mask_err),
   .index_out   (index_out)
);

// File: tb/tlb_mgmt_unit_bench.sv
module tlb_mgmt_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'd0;
   logic        small_page_en = 1'b0;
   logic [31:0] pagemask_in = '0, entryhi_in = '0, entrylo0_in = '0, entrylo1_in = '0;
   logic [31:0] index_in = '0, random_in = '0;
   logic        rd_valid, probe_valid, mask_err;
   logic [31:0] pagemask_out, entryhi_out, entrylo0_out, entrylo1_out, index_out;
   logic [4:0]  shift_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tlb_mgmt_unit u_tlb_mgmt_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .small_page_en(small_page_en), .pagemask_in(pagemask_in), .entryhi_in(entryhi_in),
      .entrylo0_in(entrylo0_in), .entrylo1_in(entrylo1_in), .index_in(index_in),
      .random_in(random_in), .rd_valid(rd_valid), .pagemask_out(pagemask_out),
      .entryhi_out(entryhi_out), .entrylo0_out(entrylo0_out), .entrylo1_out(entrylo1_out),
      .shift_out(shift_out), .probe_valid(probe_valid), .index_out(index_out),
      .mask_err(mask_err)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic        sp;
      logic [31:0] pm, ehi, lo0, lo1, idx, rnd;
      logic [31:0] x_pm, x_ehi, x_lo0, x_lo1;
      logic [4:0]  x_sh;
      logic [31:0] x_idx;
      logic        x_err;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      // R1: never-written slot reads as zeros
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      // R2 R4: indexed write with bit 31 set, small pages off
      '{2'd0, 1'b0, 32'h0, 32'h00401FA5, 32'h00048D1F, 32'h00159E12, 32'h80000003, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h3, 32'h0, 32'h00001800, 32'h004000A5, 32'h00048D1E, 32'h00159E12, 5'd12, 32'h0, 1'b0},
      // R3: replacement write lands in slot 5, not index_in
      '{2'd1, 1'b1, 32'h00007800, 32'h00006812, 32'h0002AF03, 32'h00000041, 32'h0, 32'h5, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h5, 32'h0, 32'h00007800, 32'h00006812, 32'h0002AF03, 32'h00000041, 5'd14, 32'h0, 1'b0},
      // R7: illegal mask rejected
      '{2'd0, 1'b1, 32'h00002800, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h3, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b1},
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h3, 32'h0, 32'h00001800, 32'h004000A5, 32'h00048D1E, 32'h00159E12, 5'd12, 32'h0, 1'b0},
      // R10: tag low bits cleared in probe when small pages off
      '{2'd3, 1'b0, 32'h0, 32'h004018A5, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h3, 1'b0},
      // R9 R10: asid mismatch on non-global entry
      '{2'd3, 1'b0, 32'h0, 32'h00401811, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h80000000, 1'b0},
      // R10: global entry, other asid, tag differs only under mask
      '{2'd3, 1'b1, 32'h0, 32'h00007077, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h5, 1'b0},
      '{2'd0, 1'b1, 32'h00007800, 32'h00006812, 32'h0002AF03, 32'h00000041, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      // R8: lowest slot wins
      '{2'd3, 1'b1, 32'h0, 32'h00007077, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h1, 1'b0},
      // R6: largest page
      '{2'd0, 1'b1, 32'h1FFFF800, 32'h0, 32'h0, 32'h0, 32'h7, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h7, 32'h0, 32'h1FFFF800, 32'h0, 32'h0, 32'h0, 5'd28, 32'h0, 1'b0},
      // R6: smallest page, R5 global cleared by one half
      '{2'd0, 1'b1, 32'h0, 32'h00000833, 32'h00000001, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      '{2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000833, 32'h0, 32'h0, 5'd10, 32'h0, 1'b0},
      '{2'd3, 1'b1, 32'h0, 32'h00000833, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0},
      // R10: large mask covers tag difference
      '{2'd3, 1'b1, 32'h0, 32'h00080000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 32'h7, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 rd_valid", 32'(rd_valid), 32'h0);
      chk("R1 probe_valid", 32'(probe_valid), 32'h0);
      chk("R1 mask_err", 32'(mask_err), 32'h0);
      chk("R1 index_out", index_out, 32'h0);
      chk("R1 pagemask_out", pagemask_out, 32'h0);

      for (int v = 0; v < NV; v++) begin
         op_kind       = TBL[v].kind;
         small_page_en = TBL[v].sp;
         pagemask_in   = TBL[v].pm;
         entryhi_in    = TBL[v].ehi;
         entrylo0_in   = TBL[v].lo0;
         entrylo1_in   = TBL[v].lo1;
         index_in      = TBL[v].idx;
         random_in     = TBL[v].rnd;
         op_valid      = 1'b1;
         @(negedge clk);
         op_valid = 1'b0;
         case (TBL[v].kind)
            2'd2: begin
               chk("R11 rd_valid", 32'(rd_valid), 32'h1);
               chk("R4 pagemask_out", pagemask_out, TBL[v].x_pm);
               chk("R2 entryhi_out", entryhi_out, TBL[v].x_ehi);
               chk("R5 entrylo0_out", entrylo0_out, TBL[v].x_lo0);
               chk("R5 entrylo1_out", entrylo1_out, TBL[v].x_lo1);
               chk("R6 shift_out", 32'(shift_out), 32'(TBL[v].x_sh));
            end
            2'd3: begin
               chk("R11 probe_valid", 32'(probe_valid), 32'h1);
               chk(TBL[v].x_idx[31] ? "R9 index_out" : "R8 index_out", index_out, TBL[v].x_idx);
            end
            default: begin
               chk("R7 mask_err", 32'(mask_err), 32'(TBL[v].x_err));
            end
         endcase
      end

      // R11: flags fall one cycle later; R9: index_out held
      @(negedge clk);
      chk("R11 rd_valid low", 32'(rd_valid), 32'h0);
      chk("R11 probe_valid low", 32'(probe_valid), 32'h0);
      chk("R9 index_out hold", index_out, 32'h7);

      // R4: forced mask bits with small pages off, mask 2 becomes 3
      op_kind = 2'd0; small_page_en = 1'b0; pagemask_in = 32'h00001000;
      entryhi_in = 32'h00001844; entrylo0_in = '0; entrylo1_in = '0; index_in = 32'h4;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk("R4 mask_err", 32'(mask_err), 32'h0);
      op_kind = 2'd2;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk("R4 pagemask forced", pagemask_out, 32'h00001800);
      chk("R4 entryhi cleared", entryhi_out, 32'h00000044);
      chk("R6 shift forced", 32'(shift_out), 32'd12);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule